// File: doc/BRIEF.md
# PCI Configuration Status Register

This block holds the 16-bit status word in the configuration space of a network function that can act as a bus master. Five error conditions reported by the bus interface logic are caught in sticky flags: a detected bus parity error, a driven system-error signal, a master abort the function generated, a target abort the function received, and a qualified data parity error. Each flag stays set until software writes a one to its bit position, with the byte enable for that lane active.

The other fields are read-only. Some are fixed by parameters (the DEVSEL timing code and fast back-to-back capability). One follows a strap loaded from the EEPROM (power-management capability). One is a live view of the interrupt-pending level. The reserved and unimplemented positions always read zero. The read port is combinational from the flag state and the live inputs.

Each sticky flag is a two-state machine. It has the states `FLG_CLEAR` and `FLG_LATCHED` and the following transitions:
- `catch` (CLEAR to LATCHED when its set condition is true)
- `release` (LATCHED to CLEAR on a qualified clear with no set in the same cycle)
- `hold` (every other case)

Top module: `pci_cfg_status`

## Requirements
- R1: After reset, with `pm_cap_strap`=1 and `irq_pending`=0, `rd_data` reads 0x0290.
- R2: A cycle with `ev_par_det`=1 sets bit 15, whatever the state of `perr_resp_en` and `is_master`. The bit reads 1 from the cycle after the strobe.
- R3: `ev_serr_drv` sets bit 14, `ev_mabort_gen` sets bit 13 and `ev_tabort_rcv` sets bit 12. Each bit reads 1 from the cycle after its strobe.
- R4: Bit 8 sets only in a cycle where `ev_perr_seen`, `is_master` and `perr_resp_en` are all 1. Any other combination leaves it unchanged.
- R5: A write (`wr_en`=1, `wr_be[1]`=1) with `wr_data` bit n = 1 clears sticky bit n (n in 15,14,13,12,8) from the next cycle. Writing 0 to a sticky bit has no effect.
- R6: Byte enables qualify the clear. Bits 15:8 are cleared only when `wr_be[1]`=1. A write with only `wr_be[0]` set changes no bit.
- R7: If a set condition and a clear hit the same sticky bit in the same cycle, the bit is 1 in the next cycle.
- R8: Bit 11 reads 0, bits 10:9 read 01, bit 7 reads 1, and bits 6, 5 and 2:0 read 0. Writes do not change these bits.
- R9: Bit 4 equals `pm_cap_strap` and bit 3 equals `irq_pending` in the same cycle, without a register stage. Writes do not change these bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_par_det | input | 1 | Bus parity error detected (strobe) |
| ev_serr_drv | input | 1 | Function drove the system-error signal (strobe) |
| ev_mabort_gen | input | 1 | Master abort generated as master (strobe) |
| ev_tabort_rcv | input | 1 | Target abort received as master (strobe) |
| ev_perr_seen | input | 1 | PERR# driven on a read or seen on a write (strobe) |
| is_master | input | 1 | Function currently owns the bus as master |
| perr_resp_en | input | 1 | Parity error response enable from the command register |
| pm_cap_strap | input | 1 | EEPROM power-management capability flag |
| irq_pending | input | 1 | Interrupt-pending level |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 16 | Write data; a 1 requests a clear |
| wr_be | input | 2 | Byte enables, one per lane |
| rd_data | output | 16 | Current register value |

## Verification
The bench builds the block with its default parameters: DEVSEL code 01 and fast back-to-back capability 1. With these values the whole read word can be predicted arithmetically. There are only seven event-related inputs, so the bench sweeps all 128 of their combinations from a cleared register, which covers every qualifying and non-qualifying case of the three-way data-parity condition. It then sweeps the four byte-enable settings against a set of data patterns on a fully set register. Finally it forces a set/clear collision on each of the five sticky bits in turn.

// File: rtl/pcistat_pkg.sv
package pcistat_pkg;
    localparam int STAT_W     = 16;
    localparam int LANE_W     = 8;
    localparam int LANES      = STAT_W / LANE_W;
    localparam int NUM_STICKY = 5;

    typedef enum logic {
        FLG_CLEAR   = 1'b0,
        FLG_LATCHED = 1'b1
    } flag_state_e;

    // index order: 0 data parity, 1 target abort rcvd, 2 master abort, 3 serr, 4 parity
    typedef logic [NUM_STICKY-1:0] sticky_vec_t;

    function automatic int sticky_pos(input int idx);
        case (idx)
            0:       return 8;
            1:       return 12;
            2:       return 13;
            3:       return 14;
            default: return 15;
        endcase
    endfunction
endpackage

// File: rtl/status_event_qual.sv
module status_event_qual
    import pcistat_pkg::*;
(
    input  logic        ev_par_det,
    input  logic        ev_serr_drv,
    input  logic        ev_mabort_gen,
    input  logic        ev_tabort_rcv,
    input  logic        ev_perr_seen,
    input  logic        is_master,
    input  logic        perr_resp_en,
    output sticky_vec_t set_vec
);
    always_comb begin
        set_vec    = '0;
        // R4: all three conditions must hold together
        set_vec[0] = ev_perr_seen & is_master & perr_resp_en;
        set_vec[1] = ev_tabort_rcv;
        set_vec[2] = ev_mabort_gen;
        set_vec[3] = ev_serr_drv;
        // R2: no gating by the response enable
        set_vec[4] = ev_par_det;
    end
endmodule

// File: rtl/status_clear_decode.sv
module status_clear_decode
    import pcistat_pkg::*;
(
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_be,
    output sticky_vec_t       clr_vec
);
    for (genvar i = 0; i < NUM_STICKY; i++) begin : g_clr
        localparam int POS  = sticky_pos(i);
        localparam int LANE = POS / LANE_W;
        assign clr_vec[i] = wr_en & wr_be[LANE] & wr_data[POS];
    end
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag
    import pcistat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_CLEAR:   if (set_i) state_d = FLG_LATCHED;               // catch
            FLG_LATCHED: if (clr_i && !set_i) state_d = FLG_CLEAR;       // release; set wins (R7)
            default:     state_d = FLG_CLEAR;
        endcase
    end

    always_comb begin
        flag_o = 1'b0;
        unique case (state_q)
            FLG_CLEAR:   flag_o = 1'b0;
            FLG_LATCHED: flag_o = 1'b1;
            default:     flag_o = 1'b0;
        endcase
    end

    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/pci_cfg_status.sv
module pci_cfg_status
    import pcistat_pkg::*;
#(
    parameter logic [1:0] DEVSEL_CODE = 2'b01,
    parameter logic       FAST_B2B    = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ev_par_det,
    input  logic        ev_serr_drv,
    input  logic        ev_mabort_gen,
    input  logic        ev_tabort_rcv,
    input  logic        ev_perr_seen,
    input  logic        is_master,
    input  logic        perr_resp_en,
    input  logic        pm_cap_strap,
    input  logic        irq_pending,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    input  logic [1:0]  wr_be,
    output logic [15:0] rd_data
);
    sticky_vec_t set_vec, clr_vec, flags;

    status_event_qual i_qual (
        .ev_par_det    (ev_par_det),
        .ev_serr_drv   (ev_serr_drv),
        .ev_mabort_gen (ev_mabort_gen),
        .ev_tabort_rcv (ev_tabort_rcv),
        .ev_perr_seen  (ev_perr_seen),
        .is_master     (is_master),
        .perr_resp_en  (perr_resp_en),
        .set_vec       (set_vec)
    );

    status_clear_decode i_clr (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .wr_be   (wr_be),
        .clr_vec (clr_vec)
    );

    for (genvar i = 0; i < NUM_STICKY; i++) begin : g_flag
        sticky_flag i_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[i]),
            .clr_i  (clr_vec[i]),
            .flag_o (flags[i])
        );
    end

    always_comb begin
        rd_data       = '0;
        rd_data[15]   = flags[4];
        rd_data[14]   = flags[3];
        rd_data[13]   = flags[2];
        rd_data[12]   = flags[1];
        rd_data[11]   = 1'b0;
        rd_data[10:9] = DEVSEL_CODE;
        rd_data[8]    = flags[0];
        rd_data[7]    = FAST_B2B;
        rd_data[4]    = pm_cap_strap;
        rd_data[3]    = irq_pending;
    end

    a_r2_parity_ungated: assert property (@(posedge clk) disable iff (!rst_n)
        ev_par_det |=> rd_data[15]);
    a_r4_dpe_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ev_perr_seen && is_master && perr_resp_en) && !rd_data[8]) |=> !rd_data[8]);
    a_r6_low_lane_safe: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_be[1] && rd_data[15]) |=> rd_data[15]);
    a_r3_serr_caught: assert property (@(posedge clk) disable iff (!rst_n)
        ev_serr_drv |=> rd_data[14]);
endmodule

// File: tb/test_pci_cfg_status.sv
module test_pci_cfg_status;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_par_det = 0, ev_serr_drv = 0, ev_mabort_gen = 0, ev_tabort_rcv = 0;
    logic ev_perr_seen = 0, is_master = 0, perr_resp_en = 0;
    logic pm_cap_strap = 1, irq_pending = 0, wr_en = 0;
    logic [15:0] wr_data = '0;
    logic [1:0]  wr_be = '0;
    logic [15:0] rd_data;
    logic [4:0]  model;   // order: 15,14,13,12,8
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    pci_cfg_status i_pci_cfg_status (
        .clk(clk), .rst_n(rst_n), .ev_par_det(ev_par_det), .ev_serr_drv(ev_serr_drv),
        .ev_mabort_gen(ev_mabort_gen), .ev_tabort_rcv(ev_tabort_rcv),
        .ev_perr_seen(ev_perr_seen), .is_master(is_master), .perr_resp_en(perr_resp_en),
        .pm_cap_strap(pm_cap_strap), .irq_pending(irq_pending), .wr_en(wr_en),
        .wr_data(wr_data), .wr_be(wr_be), .rd_data(rd_data)
    );

    function automatic logic [15:0] expect_word(logic [4:0] m, logic strap, logic irq);
        return {m[4], m[3], m[2], m[1], 1'b0, 2'b01, m[0], 1'b1, 2'b00, strap, irq, 3'b000};
    endfunction

    task automatic check(string req, logic [15:0] exp);
        total++;
        if (rd_data !== exp) begin
            bad++;
            $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
        end
    endtask

    // ev = {par, serr, mab, tab, perr, master, resp}
    task automatic cycle(logic [6:0] ev, logic we, logic [15:0] d, logic [1:0] be, string req);
        logic [4:0] setv, clrv;
        @(negedge clk);
        {ev_par_det, ev_serr_drv, ev_mabort_gen, ev_tabort_rcv, ev_perr_seen, is_master, perr_resp_en} = ev;
        wr_en = we; wr_data = d; wr_be = be;
        setv = {ev[6], ev[5], ev[4], ev[3], ev[2] & ev[1] & ev[0]};
        clrv = (we && be[1]) ? {d[15], d[14], d[13], d[12], d[8]} : 5'b0;
        model = setv | (model & ~clrv);
        @(negedge clk);
        {ev_par_det, ev_serr_drv, ev_mabort_gen, ev_tabort_rcv, ev_perr_seen, is_master, perr_resp_en} = '0;
        wr_en = 0; wr_data = '0; wr_be = '0;
        #1 check(req, expect_word(model, pm_cap_strap, irq_pending));
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] pats [6];
        pats = '{16'h0000, 16'hFFFF, 16'h00FF, 16'hFF00, 16'hA5A5, 16'h5A5A};
        model = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 check("R1 reset", 16'h0290);

        // R2 R3 R4: every event combination from a cleared register
        for (int p = 0; p < 128; p++) begin
            @(negedge clk);
            irq_pending = p[1]; pm_cap_strap = p[2];
            #1 check("R9 live bits", expect_word(model, pm_cap_strap, irq_pending));
            cycle(p[6:0], 1'b0, 16'h0, 2'b00, "R2 R3 R4 event sweep");
            cycle(7'h0, 1'b1, 16'hFFFF, 2'b11, "R5 clear all");
        end

        // R5 R6 R8: byte-enable and data sweep on a fully set register
        for (int be = 0; be < 4; be++) begin
            for (int k = 0; k < 6; k++) begin
                cycle(7'h7F, 1'b0, 16'h0, 2'b00, "R3 set all");
                cycle(7'h00, 1'b1, pats[k], be[1:0], "R5 R6 R8 write sweep");
            end
        end

        // R7: collision per sticky bit
        for (int b = 0; b < 5; b++) begin
            logic [6:0] ev;
            cycle(7'h7F, 1'b0, 16'h0, 2'b00, "R3 set all");
            ev = (b == 0) ? 7'b0000111 : (7'b0000100 << b);
            cycle(ev, 1'b1, 16'hFFFF, 2'b11, "R7 set beats clear");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule